// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave that holds a six-byte configuration register file for a clock generator. A fast system clock samples SCL and SDA. START and STOP conditions are recognised on the sampled lines, and the slave drives SDA only as an open-drain pull-down. The six register bytes leave the block as one parallel vector, and the rest of the chip uses them for frequency, spread and stop-clock settings.

A host writes with a block transfer to the 8-bit address 0xD2. The slave acknowledges a command byte and a length byte and then discards both. The data bytes that follow fill register 0, then 1, and so on upwards. A host reads with the address 0xD3. The slave returns a length byte first and then every register in ascending order. Each transfer always starts at register 0, and no random access is possible.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit device address 0x69, which is the 8-bit value 0xD2 for a write and 0xD3 for a read. For any other address it leaves SDA released for that byte and for every byte up to the next START.
- R2: On a write, the slave acknowledges the first two bytes after the address and changes no register with them.
- R3: On a write, the third and later bytes go to register 0, 1, 2, 3, 4 and 5 in that order, and the slave acknowledges each one. Register k appears on `cfg_bytes[8k+7:8k]`.
- R4: A STOP after any complete byte ends the write. Registers already written keep their new values, and registers not reached keep their previous values.
- R5: Write bytes beyond the sixth data byte are acknowledged and change no register.
- R6: After reset, register 0 holds 0x00 and registers 1 to 5 hold 0xFF, and SDA is released.
- R7: On a read, the slave sends the value 6 first and then registers 0 to 5, each byte most significant bit first.
- R8: During a read, a not-acknowledge from the host ends transmission. The slave keeps SDA released for any further clocks until the next START.
- R9: A byte cut short by a STOP or a repeated START updates no register.
- R10: If the host acknowledges the last register byte of a read, every further byte reads as 0xFF.
- R11: The slave changes SDA only while SCL is low. A change of its drive follows a falling SCL edge, or a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line (the wired bus value) |
| sda_oe | output | 1 | High while the slave pulls SDA low |
| sda_out | output | 1 | Data value driven while enabled; always 0 (open drain) |
| cfg_bytes | output | 48 | Register file, register k in bits 8k+7 to 8k |

## Verification
The assertions rely on the host changing SDA only while SCL is low, except when it forms a START or STOP. They also rely on every SCL high or low phase lasting longer than the synchronizer delay, so that each edge produces exactly one event. The bench master keeps each quarter bit at ten system clocks and moves SDA only in the low phase or at deliberate START and STOP points. Its cut-byte scenarios end a byte only on a bit boundary, and that boundary lies within the same rules.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int unsigned CFG_BYTES   = 6;
    localparam int unsigned HDR_BYTES   = 2;
    localparam int unsigned SYNC_STAGES = 2;
    localparam logic [6:0]  DEV_ADDR7   = 7'h69;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WDATA,
        ST_TX,
        ST_RACK
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic [CFG_BYTES*8-1:0] default_image();
        return {{(CFG_BYTES-1){8'hFF}}, 8'h00};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_cfg_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_comb begin
        evt.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        evt.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
        evt.scl_rise = scl_now & ~scl_prev;
        evt.scl_fall = ~scl_now & scl_prev;
        evt.sda      = sda_now;
    end

endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile
    import i2c_cfg_pkg::*;
#(
    parameter int unsigned           N_BYTES = CFG_BYTES,
    parameter int unsigned           IDX_W   = 4,
    parameter logic [N_BYTES*8-1:0]  INIT    = default_image()
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        waddr,
    input  logic [7:0]              wdata,
    output logic [N_BYTES*8-1:0]    cfg_q
);

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= INIT[g*8 +: 8];
            end else if (we && (waddr == IDX_W'(g))) begin
                byte_q <= wdata;
            end
        end
        assign cfg_q[g*8 +: 8] = byte_q;
    end

    AST_WADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        we |-> (waddr < IDX_W'(N_BYTES)));  // R5

    AST_RESET_IMAGE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == INIT));  // R6

endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
    import i2c_cfg_pkg::*;
#(
    parameter int unsigned N_BYTES  = CFG_BYTES,
    parameter int unsigned IDX_W    = 4,
    parameter logic [6:0]  DEV_ADDR = DEV_ADDR7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bus_evt_t              bus,
    input  logic [N_BYTES*8-1:0]  cfg_q,
    output logic                  sda_oe,
    output logic                  reg_we,
    output logic [IDX_W-1:0]      reg_waddr,
    output logic [7:0]            reg_wdata
);

    localparam logic [IDX_W-1:0] HDR_IDX  = IDX_W'(HDR_BYTES);
    localparam logic [IDX_W-1:0] WR_LAST  = IDX_W'(HDR_BYTES + N_BYTES);
    localparam logic [IDX_W-1:0] RD_LAST  = IDX_W'(N_BYTES + 1);

    phase_e           phase;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic             rd_mode;
    logic             host_ack;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] rd_nxt;
    logic [7:0]       tx_cur;
    logic [7:0]       tx_nxt;

    function automatic logic [7:0] tx_byte(input logic [IDX_W-1:0] idx,
                                           input logic [N_BYTES*8-1:0] img);
        logic [7:0] val;
        val = 8'hFF;
        if (idx == '0) begin
            val = 8'(N_BYTES);
        end else begin
            for (int k = 0; k < N_BYTES; k++) begin
                if (idx == IDX_W'(k + 1)) val = img[k*8 +: 8];
            end
        end
        return val;
    endfunction

    assign rd_nxt = (rd_idx < RD_LAST) ? rd_idx + 1'b1 : rd_idx;
    assign tx_cur = tx_byte(rd_idx, cfg_q);
    assign tx_nxt = tx_byte(rd_nxt, cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            rd_mode   <= 1'b0;
            host_ack  <= 1'b0;
            wr_idx    <= '0;
            rd_idx    <= '0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (bus.stop) begin
                phase  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (bus.start) begin
                phase   <= ST_ADDR;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else begin
                unique case (phase)
                    ST_ADDR, ST_WDATA: begin
                        if (bus.scl_rise && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], bus.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (bus.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (phase == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe  <= 1'b1;
                                    phase   <= ST_ACK;
                                    rd_mode <= shreg[0];
                                    wr_idx  <= '0;
                                    rd_idx  <= '0;
                                end else begin
                                    phase <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                phase  <= ST_ACK;
                                if (wr_idx >= HDR_IDX && wr_idx < WR_LAST) begin
                                    reg_we    <= 1'b1;
                                    reg_waddr <= wr_idx - HDR_IDX;
                                    reg_wdata <= shreg;
                                end
                                if (wr_idx < WR_LAST) wr_idx <= wr_idx + 1'b1;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (bus.scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_mode) begin
                                shreg  <= tx_cur;
                                sda_oe <= ~tx_cur[7];
                                phase  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= ST_WDATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (bus.scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                phase  <= ST_RACK;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b1};
                                sda_oe  <= ~shreg[6];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (bus.scl_rise) begin
                            host_ack <= ~bus.sda;
                        end else if (bus.scl_fall) begin
                            bit_cnt <= '0;
                            if (host_ack) begin
                                rd_idx <= rd_nxt;
                                shreg  <= tx_nxt;
                                sda_oe <= ~tx_nxt[7];
                                phase  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_MOVES_ON_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(bus.scl_fall || bus.start || bus.stop));  // R11

    AST_COMMIT_FULL_BYTE: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(phase == ST_WDATA && bus.scl_fall && bit_cnt == 4'd8));  // R9

    AST_ADDR_ACK_MATCH: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && phase == ST_ACK && $past(phase) == ST_ADDR)
            |-> ($past(shreg[7:1]) == DEV_ADDR));  // R1

    AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IDLE) |-> !sda_oe);  // R8

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int unsigned          N_BYTES  = CFG_BYTES,
    parameter logic [6:0]           DEV_ADDR = DEV_ADDR7,
    parameter logic [N_BYTES*8-1:0] INIT     = default_image()
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic                   sda_out,
    output logic [N_BYTES*8-1:0]   cfg_bytes
);

    localparam int unsigned IDX_W = $clog2(N_BYTES + HDR_BYTES + 2);

    bus_evt_t         bus;
    logic             reg_we;
    logic [IDX_W-1:0] reg_waddr;
    logic [7:0]       reg_wdata;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (bus)
    );

    i2c_cfg_engine #(
        .N_BYTES  (N_BYTES),
        .IDX_W    (IDX_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .bus       (bus),
        .cfg_q     (cfg_bytes),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata)
    );

    i2c_cfg_regfile #(
        .N_BYTES (N_BYTES),
        .IDX_W   (IDX_W),
        .INIT    (INIT)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .cfg_q (cfg_bytes)
    );

    assign sda_out = 1'b0;

endmodule

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic        sda_out;
    logic [47:0] cfg_bytes;
    logic        sda_line;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    bit unstable_seen = 1'b0;

    logic [47:0] model;

    always #10 clk = ~clk;

    assign sda_line = sda_oe ? sda_out : m_sda;

    i2c_cfg_slave u_i2c_cfg_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .sda_out   (sda_out),
        .cfg_bytes (cfg_bytes)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        logic early;
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(2);
        early = sda_line;
        tick(2*Q - 4);
        b = sda_line;
        if (early !== b) unstable_seen = 1'b1;
        tick(2);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~give_ack);
    endtask

    task automatic t_reset();
        check(cfg_bytes === 48'hFFFF_FFFF_FF00, "R6 reset image", cfg_bytes, 48'hFFFF_FFFF_FF00);
        check(sda_oe === 1'b0, "R6 sda released", sda_oe, 0);
    endtask

    task automatic t_full_write();
        logic a;
        logic all_ack = 1'b1;
        bus_start();
        send_byte(8'hD2, a); check(a, "R1 write addr ack", a, 1);
        send_byte(8'hA5, a); check(a, "R2 command ack", a, 1);
        send_byte(8'h3C, a); check(a, "R2 count ack", a, 1);
        check(cfg_bytes === model, "R2 header no effect", cfg_bytes, model);
        for (int k = 0; k < 6; k++) begin
            send_byte(8'h11 * (k + 1), a);
            all_ack &= a;
            model[k*8 +: 8] = 8'h11 * (k + 1);
        end
        bus_stop();
        check(all_ack, "R3 data acks", all_ack, 1);
        check(cfg_bytes === model, "R3 sequential write", cfg_bytes, model);
    endtask

    task automatic t_readback();
        logic a;
        logic [7:0] v;
        logic [47:0] got;
        unstable_seen = 1'b0;
        bus_start();
        send_byte(8'hD3, a); check(a, "R1 read addr ack", a, 1);
        recv_byte(1'b1, v);  check(v === 8'd6, "R7 count byte", v, 6);
        for (int k = 0; k < 6; k++) begin
            recv_byte(k != 5, v);
            got[k*8 +: 8] = v;
        end
        check(got === model, "R7 read data", got, model);
        check(!unstable_seen, "R11 SDA stable while SCL high", unstable_seen, 0);
        bus_stop();
    endtask

    task automatic t_nack_end();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, v);
        recv_byte(1'b0, v);
        check(v === model[7:0], "R8 first reg before nack", v, model[7:0]);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        check(v === 8'hFF, "R8 released after nack", v, 8'hFF);
        get_bit(a);
        check(sda_oe === 1'b0, "R8 no drive after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_read_past_end();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, v);
        for (int k = 0; k < 6; k++) recv_byte(1'b1, v);
        recv_byte(1'b1, v); check(v === 8'hFF, "R10 pad byte 1", v, 8'hFF);
        recv_byte(1'b0, v); check(v === 8'hFF, "R10 pad byte 2", v, 8'hFF);
        bus_stop();
    endtask

    task automatic t_partial_write();
        logic a;
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'hA1, a); send_byte(8'hA2, a);
        bus_stop();
        model[7:0] = 8'hA1; model[15:8] = 8'hA2;
        check(cfg_bytes === model, "R4 partial write", cfg_bytes, model);
    endtask

    task automatic t_overrun();
        logic a;
        logic all_ack = 1'b1;
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h01, a); send_byte(8'h02, a);
        for (int k = 0; k < 8; k++) begin
            send_byte(8'hB0 + 8'(k), a);
            all_ack &= a;
            if (k < 6) model[k*8 +: 8] = 8'hB0 + 8'(k);
        end
        bus_stop();
        check(all_ack, "R5 extra bytes acked", all_ack, 1);
        check(cfg_bytes === model, "R5 extra bytes discarded", cfg_bytes, model);
    endtask

    task automatic t_cut_bytes();
        logic a;
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'hC1, a);
        for (int i = 7; i >= 4; i--) put_bit(1'b0);
        bus_stop();
        model[7:0] = 8'hC1;
        check(cfg_bytes === model, "R9 cut by stop", cfg_bytes, model);
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        for (int i = 7; i >= 3; i--) put_bit(1'b1);
        bus_start();
        bus_stop();
        check(cfg_bytes === model, "R9 cut by repeated start", cfg_bytes, model);
    endtask

    task automatic t_bad_addr();
        logic a;
        logic any_ack = 1'b0;
        bus_start();
        send_byte(8'hD4, a); check(!a, "R1 foreign addr nack", a, 0);
        for (int k = 0; k < 4; k++) begin
            send_byte(8'h00, a);
            any_ack |= a;
        end
        bus_stop();
        check(!any_ack, "R1 silent until start", any_ack, 0);
        check(cfg_bytes === model, "R1 foreign write no effect", cfg_bytes, model);
    endtask

    initial begin
        model = 48'hFFFF_FFFF_FF00;
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_full_write();
        t_readback();
        t_nack_end();
        t_read_past_end();
        t_partial_write();
        t_overrun();
        t_cut_bytes();
        t_bad_addr();
        t_readback();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule